// File: doc/BRIEF.md
# Time-Division-Multiplexed Serial Bus Node

This block is one station on a shared four-wire serial bus that links up to eight devices. The wires are a bit clock, a frame marker, a slot-address line and a slot-data line. A frame opens with one marker bit time and then carries eight slots of one word each. In every slot only the station that owns it drives the two shared lines. The address line announces the sender's identity, so listeners choose words by source and not by slot number.

Each station holds one outgoing word and one incoming word. When a slot it owns begins, the station moves its outgoing word onto the wire. At the end of any slot whose sender it has been told to accept, it captures the word together with the sender's identity. It flags a host interrupt when its outgoing buffer is drained and another when its incoming buffer fills. One station on the bus is strapped as master and produces the bit clock and the frame marker for all of them. The others follow the bus clock, which they oversample in the system clock domain. The shared lines are wired-OR: each station provides a value and an enable, and the bus is the OR of the enabled values.

Top module: `tdm_node`

## Requirements
- R1: With `is_master` high, `bclk_o` toggles every `HALF_DIV` system clocks, so it stays high for exactly `HALF_DIV` cycles. With `is_master` low, `bclk_o` and `fsync_o` stay 0.
- R2: A frame lasts 1 + SLOTS*WORD_W bus-clock periods (129 by default). `fsync_o` rises together with a rising bus-clock edge, stays high for one bit time (2*HALF_DIV clocks), and the next rising edge begins bit 0 of slot 0.
- R3: `data_oe` and `addr_oe` are high only during slots whose bit in `tx_mask` is set, which is 2*HALF_DIV*WORD_W clocks per owned slot. `data_o` carries the word MSB first and changes only in the cycle after a detected rising bus-clock edge.
- R4: In an owned slot the address line carries a 1 in bit time 0, the node's 3-bit `my_addr` MSB first in bit times 1 to 3, and 0 for the rest of the slot.
- R5: At the start of an owned slot, a full output buffer is moved to the wire and `tx_full` falls. `tx_empty_irq` is a one-cycle pulse in the same cycle that `addr_oe` rises.
- R6: If an owned slot starts with the output buffer empty, the node sends all zeros and sets `tx_underrun`. The flag stays set until the next `tx_we`.
- R7: A slot's word is captured only if its address bit time 0 read 1 and `rx_mask[source]` is set. It then appears on `rx_word` with its source on `rx_src`, and `rx_full` is set. Undriven slots read as 0 and are never captured.
- R8: `rx_full_irq` pulses for one cycle at each capture, and `rx_full` is 1 in that cycle. `rx_rd` clears `rx_full`. An unread word is overwritten by the next accepted word.
- R9: Words from sources whose `rx_mask` bit is clear cause no capture, no interrupt and no change of `rx_full`.
- R10: During reset all outputs are 0 and the node drives no bus line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | Strap: generate bus clock and frame marker |
| my_addr | input | 3 | Identity sent on the address line |
| tx_mask | input | 8 | Slots this node owns, one bit per slot |
| rx_mask | input | 8 | Sources accepted, one bit per source address |
| tx_we | input | 1 | Write `tx_wdata` into the output buffer |
| tx_wdata | input | 16 | Outgoing word |
| tx_full | output | 1 | Output buffer holds a word |
| tx_underrun | output | 1 | An owned slot found the buffer empty |
| tx_empty_irq | output | 1 | Pulse: output buffer drained onto the wire |
| rx_rd | input | 1 | Release the input buffer |
| rx_full | output | 1 | Input buffer holds an unread word |
| rx_word | output | 16 | Last accepted word |
| rx_src | output | 3 | Source address of `rx_word` |
| rx_full_irq | output | 1 | Pulse: a word was captured |
| bclk_o | output | 1 | Generated bus clock (master only) |
| fsync_o | output | 1 | Generated frame marker (master only) |
| bclk_i | input | 1 | Bus clock from the bus |
| fsync_i | input | 1 | Frame marker from the bus |
| addr_i | input | 1 | Address line from the bus |
| addr_o | output | 1 | Address line value |
| addr_oe | output | 1 | Address line drive enable |
| data_i | input | 1 | Data line from the bus |
| data_o | output | 1 | Data line value |
| data_oe | output | 1 | Data line drive enable |

## Verification
A slot counter that is off by one bit time moves a station's drive window. Within one frame the listeners then capture a shifted word or a wrong source, and the owner's drive-enable time per frame no longer matches. A lost frame-start condition silences the station for a whole frame: no capture interrupts arrive and the underrun flags are wrong at the next marker. Faults in the buffer flags show up at the next owned slot boundary, as a missing or extra drain pulse or a zero word on the wire. Several stations are wired to one bus with random masks and words, so any of these faults changes the per-frame capture sequence that the bench compares word by word.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
   // bus lines besides the clock, carried through the synchronizer together
   typedef struct packed {
      logic fsync;
      logic addr;
      logic data;
   } tdm_lines_t;

   // edge events of the oversampled bus clock, one system cycle wide
   typedef struct packed {
      logic rise;
      logic fall;
   } tdm_edges_t;

   // marker bit that opens the address field of a driven slot
   localparam int unsigned TDM_MARK_BITS = 1;
endpackage

// File: rtl/tdm_sync.sv
module tdm_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bclk_i,
   input  tdm_pkg::tdm_lines_t  lines_i,
   output tdm_pkg::tdm_lines_t  lines_o,
   output tdm_pkg::tdm_edges_t  edges_o
);
   localparam int unsigned W = 4;

   logic [W-1:0] stg [STAGES];
   logic         bclk_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("tdm_sync: at least two synchronizer stages required");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= {bclk_i, lines_i};
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) bclk_q <= 1'b0;
      else        bclk_q <= stg[STAGES-1][W-1];

   assign lines_o      = stg[STAGES-1][W-2:0];
   assign edges_o.rise =  stg[STAGES-1][W-1] & ~bclk_q;
   assign edges_o.fall = ~stg[STAGES-1][W-1] &  bclk_q;
endmodule

// File: rtl/tdm_clkgen.sv
module tdm_clkgen #(
   parameter int unsigned HALF_DIV   = 4,
   parameter int unsigned FRAME_BITS = 129
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic bclk_o,
   output logic fsync_o
);
   localparam int unsigned DIV_W = $clog2(HALF_DIV + 1);
   localparam int unsigned FB_W  = $clog2(FRAME_BITS);

   logic [DIV_W-1:0] div_q;
   logic [FB_W-1:0]  bit_q;
   logic             bclk_q, fs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         bit_q  <= '0;
         bclk_q <= 1'b0;
         fs_q   <= 1'b0;
      end else if (!run) begin
         div_q  <= '0;
         bit_q  <= '0;
         bclk_q <= 1'b0;
         fs_q   <= 1'b0;
      end else if (div_q == DIV_W'(HALF_DIV - 1)) begin
         div_q  <= '0;
         bclk_q <= ~bclk_q;
         if (!bclk_q) begin
            // rising edge: frame marker occupies bit time 0 of the frame
            fs_q  <= (bit_q == '0);
            bit_q <= (bit_q == FB_W'(FRAME_BITS - 1)) ? '0 : bit_q + 1'b1;
         end
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   assign bclk_o  = bclk_q;
   assign fsync_o = fs_q;

   AST_FSYNC_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fs_q) |-> $rose(bclk_q)); // R2
   AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!bclk_q && !fs_q)); // R1
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned BIT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              own_now,
   input  logic [BIT_W-1:0]  cur_bit,
   input  logic [ADDR_W-1:0] my_addr,
   input  logic              tx_we,
   input  logic [WORD_W-1:0] tx_wdata,
   output logic              tx_full,
   output logic              tx_underrun,
   output logic              tx_empty_irq,
   output logic              addr_o,
   output logic              addr_oe,
   output logic              data_o,
   output logic              data_oe
);
   localparam int unsigned PAD_W = WORD_W - ADDR_W - tdm_pkg::TDM_MARK_BITS;

   logic [WORD_W-1:0] buf_q, word_q, addr_pat;
   logic              full_q, und_q, irq_q;
   logic [BIT_W-1:0]  msb_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         word_q <= '0;
         full_q <= 1'b0;
         und_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (load) begin
            if (full_q) begin
               word_q <= buf_q;
               irq_q  <= 1'b1;
            end else begin
               word_q <= '0;
               und_q  <= 1'b1;
            end
         end
         if (tx_we) begin
            buf_q  <= tx_wdata;
            full_q <= 1'b1;
            if (!(load && !full_q)) und_q <= 1'b0;
         end else if (load) begin
            full_q <= 1'b0;
         end
      end
   end

   // marker, identity MSB first, then zero padding for the rest of the slot
   assign addr_pat = {1'b1, my_addr, {PAD_W{1'b0}}};
   assign msb_idx  = ~cur_bit;

   assign addr_oe      = own_now;
   assign data_oe      = own_now;
   assign addr_o       = own_now & addr_pat[msb_idx];
   assign data_o       = own_now & word_q[msb_idx];
   assign tx_full      = full_q;
   assign tx_underrun  = und_q;
   assign tx_empty_irq = irq_q;

   AST_UNDERRUN_SENDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(und_q) |-> (data_oe && !data_o)); // R6
   AST_EMPTY_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q); // R5
   AST_EMPTY_IRQ_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !$past(tx_we)) |-> !full_q); // R5
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned BIT_W  = 4,
   parameter int unsigned SLOTS  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic [BIT_W-1:0]  cur_bit,
   input  logic              addr_in,
   input  logic              data_in,
   input  logic [SLOTS-1:0]  rx_mask,
   input  logic              rx_rd,
   output logic              rx_full,
   output logic [WORD_W-1:0] rx_word,
   output logic [ADDR_W-1:0] rx_src,
   output logic              rx_full_irq
);
   logic              mark_q, full_q, irq_q;
   logic [ADDR_W-1:0] src_sh, src_q;
   logic [WORD_W-1:0] sh_q, word_q;
   logic              take;

   assign take = sample && (&cur_bit) && mark_q && rx_mask[src_sh];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mark_q <= 1'b0;
         src_sh <= '0;
         sh_q   <= '0;
         src_q  <= '0;
         word_q <= '0;
         full_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (sample) begin
            sh_q <= {sh_q[WORD_W-2:0], data_in};
            if (cur_bit == '0)
               mark_q <= addr_in;
            else if (cur_bit <= BIT_W'(ADDR_W))
               src_sh <= {src_sh[ADDR_W-2:0], addr_in};
         end
         if (take) begin
            word_q <= {sh_q[WORD_W-2:0], data_in};
            src_q  <= src_sh;
            full_q <= 1'b1;
            irq_q  <= 1'b1;
         end else if (rx_rd) begin
            full_q <= 1'b0;
         end
      end
   end

   assign rx_full     = full_q;
   assign rx_word     = word_q;
   assign rx_src      = src_q;
   assign rx_full_irq = irq_q;

   AST_IRQ_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> full_q); // R8
   AST_FULL_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(full_q) |-> $past(rx_rd)); // R8
   AST_WORD_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_q |-> $stable(src_q)); // R9
endmodule

// File: rtl/tdm_node.sv
module tdm_node #(
   parameter int unsigned SLOTS       = 8,
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned HALF_DIV    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MASTER_EN   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        is_master,
   input  logic [2:0]  my_addr,
   input  logic [7:0]  tx_mask,
   input  logic [7:0]  rx_mask,
   input  logic        tx_we,
   input  logic [15:0] tx_wdata,
   output logic        tx_full,
   output logic        tx_underrun,
   output logic        tx_empty_irq,
   input  logic        rx_rd,
   output logic        rx_full,
   output logic [15:0] rx_word,
   output logic [2:0]  rx_src,
   output logic        rx_full_irq,
   output logic        bclk_o,
   output logic        fsync_o,
   input  logic        bclk_i,
   input  logic        fsync_i,
   input  logic        addr_i,
   output logic        addr_o,
   output logic        addr_oe,
   input  logic        data_i,
   output logic        data_o,
   output logic        data_oe
);
   localparam int unsigned ADDR_W     = $clog2(SLOTS);
   localparam int unsigned BIT_W      = $clog2(WORD_W);
   localparam int unsigned POS_W      = ADDR_W + BIT_W;
   localparam int unsigned FRAME_BITS = SLOTS * WORD_W + 1;

   if ((1 << ADDR_W) != SLOTS || SLOTS < 4 || SLOTS != 8) begin : g_bad_slots
      $error("tdm_node: slot count must be eight to match the mask ports");
   end
   if ((1 << BIT_W) != WORD_W || WORD_W != 16) begin : g_bad_word
      $error("tdm_node: word width must be sixteen to match the data ports");
   end
   if (HALF_DIV < SYNC_STAGES + 1) begin : g_bad_div
      $error("tdm_node: bus clock half period too short for the synchronizer");
   end

   tdm_pkg::tdm_lines_t raw_l, ln;
   tdm_pkg::tdm_edges_t ev;

   assign raw_l = '{fsync: fsync_i, addr: addr_i, data: data_i};

   tdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .bclk_i  (bclk_i),
      .lines_i (raw_l),
      .lines_o (ln),
      .edges_o (ev)
   );

   if (MASTER_EN) begin : g_master
      tdm_clkgen #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_gen (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (is_master),
         .bclk_o  (bclk_o),
         .fsync_o (fsync_o)
      );
   end else begin : g_follower
      assign bclk_o  = 1'b0;
      assign fsync_o = 1'b0;
   end

   // frame position: slot in the upper bits, bit time in the lower bits
   logic             active_q, start_q;
   logic [POS_W-1:0] pos_q;
   logic [ADDR_W-1:0] cur_slot, next_slot;
   logic [BIT_W-1:0]  cur_bit;
   logic              slot_start, own_now, load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         start_q  <= 1'b0;
         pos_q    <= '0;
      end else begin
         if (ev.fall && ln.fsync) start_q <= 1'b1;
         if (ev.rise) begin
            if (start_q) begin
               active_q <= 1'b1;
               pos_q    <= '0;
               start_q  <= 1'b0;
            end else if (active_q) begin
               if (&pos_q) active_q <= 1'b0;
               pos_q <= pos_q + 1'b1;
            end
         end
      end
   end

   assign cur_slot   = pos_q[POS_W-1:BIT_W];
   assign cur_bit    = pos_q[BIT_W-1:0];
   assign next_slot  = start_q ? '0 : cur_slot + 1'b1;
   assign slot_start = ev.rise && (start_q || (active_q && (&cur_bit) && !(&pos_q)));
   assign load       = slot_start && tx_mask[next_slot];
   assign own_now    = active_q && tx_mask[cur_slot];

   tdm_tx #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (load),
      .own_now      (own_now),
      .cur_bit      (cur_bit),
      .my_addr      (my_addr),
      .tx_we        (tx_we),
      .tx_wdata     (tx_wdata),
      .tx_full      (tx_full),
      .tx_underrun  (tx_underrun),
      .tx_empty_irq (tx_empty_irq),
      .addr_o       (addr_o),
      .addr_oe      (addr_oe),
      .data_o       (data_o),
      .data_oe      (data_oe)
   );

   tdm_rx #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W), .SLOTS(SLOTS)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample      (ev.fall && active_q),
      .cur_bit     (cur_bit),
      .addr_in     (ln.addr),
      .data_in     (ln.data),
      .rx_mask     (rx_mask),
      .rx_rd       (rx_rd),
      .rx_full     (rx_full),
      .rx_word     (rx_word),
      .rx_src      (rx_src),
      .rx_full_irq (rx_full_irq)
   );

   AST_DRIVE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ev.rise) |-> ($stable(data_o) && $stable(data_oe))); // R3
   AST_EMPTY_IRQ_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty_irq |-> (addr_oe && addr_o)); // R5
endmodule

// File: tb/tb_tdm_node.sv
module tb_tdm_node;
   localparam int HALF = 4;
   localparam int NF   = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   localparam logic [2:0] ADR [3] = '{3'd1, 3'd4, 3'd6};
   localparam logic [7:0] TXM [3] = '{8'h0A, 8'h10, 8'h40};

   logic [7:0]  rxm [3];
   logic [2:0]  init_we, mon_rd, man_rd, we, rd;
   logic        mon_we0;
   logic [15:0] init_wd [3];
   logic [15:0] mon_wd0;
   logic [15:0] wd [3];
   logic [2:0]  txf, und, eirq, rxf, rirq, bo, fo, a_o, a_oe, d_o, d_oe;
   logic [15:0] rxw [3];
   logic [2:0]  rxs [3];
   logic        bus_bclk, bus_fs, bus_addr, bus_data;

   assign bus_bclk = bo[0];
   assign bus_fs   = fo[0];
   assign bus_addr = |(a_o & a_oe);
   assign bus_data = |(d_o & d_oe);
   assign we = init_we | {2'b00, mon_we0};
   assign rd = mon_rd | man_rd;
   assign wd[0] = mon_we0 ? mon_wd0 : init_wd[0];
   assign wd[1] = init_wd[1];
   assign wd[2] = init_wd[2];

   tdm_node dut (
      .clk(clk), .rst_n(rst_n), .is_master(1'b1), .my_addr(ADR[0]),
      .tx_mask(TXM[0]), .rx_mask(rxm[0]), .tx_we(we[0]), .tx_wdata(wd[0]),
      .tx_full(txf[0]), .tx_underrun(und[0]), .tx_empty_irq(eirq[0]),
      .rx_rd(rd[0]), .rx_full(rxf[0]), .rx_word(rxw[0]), .rx_src(rxs[0]),
      .rx_full_irq(rirq[0]), .bclk_o(bo[0]), .fsync_o(fo[0]),
      .bclk_i(bus_bclk), .fsync_i(bus_fs), .addr_i(bus_addr),
      .addr_o(a_o[0]), .addr_oe(a_oe[0]), .data_i(bus_data),
      .data_o(d_o[0]), .data_oe(d_oe[0]));

   tdm_node n1 (
      .clk(clk), .rst_n(rst_n), .is_master(1'b0), .my_addr(ADR[1]),
      .tx_mask(TXM[1]), .rx_mask(rxm[1]), .tx_we(we[1]), .tx_wdata(wd[1]),
      .tx_full(txf[1]), .tx_underrun(und[1]), .tx_empty_irq(eirq[1]),
      .rx_rd(rd[1]), .rx_full(rxf[1]), .rx_word(rxw[1]), .rx_src(rxs[1]),
      .rx_full_irq(rirq[1]), .bclk_o(bo[1]), .fsync_o(fo[1]),
      .bclk_i(bus_bclk), .fsync_i(bus_fs), .addr_i(bus_addr),
      .addr_o(a_o[1]), .addr_oe(a_oe[1]), .data_i(bus_data),
      .data_o(d_o[1]), .data_oe(d_oe[1]));

   tdm_node n2 (
      .clk(clk), .rst_n(rst_n), .is_master(1'b0), .my_addr(ADR[2]),
      .tx_mask(TXM[2]), .rx_mask(rxm[2]), .tx_we(we[2]), .tx_wdata(wd[2]),
      .tx_full(txf[2]), .tx_underrun(und[2]), .tx_empty_irq(eirq[2]),
      .rx_rd(rd[2]), .rx_full(rxf[2]), .rx_word(rxw[2]), .rx_src(rxs[2]),
      .rx_full_irq(rirq[2]), .bclk_o(bo[2]), .fsync_o(fo[2]),
      .bclk_i(bus_bclk), .fsync_i(bus_fs), .addr_i(bus_addr),
      .addr_o(a_o[2]), .addr_oe(a_oe[2]), .data_i(bus_data),
      .data_o(d_o[2]), .data_oe(d_oe[2]));

   // expected per-frame state
   logic [15:0] slot_word [8];
   int  exp_slot [3][4];
   int  exp_n [3], got_n [3];
   bit  skip [3];
   bit  second, hold2;
   int  irq_k;

   // monitor state
   bit  prev_bclk, prev_fs, prev_oe0, bclk_bad, slave_bad;
   int  hi_len, fs_len, fs_len_snap, rise_cnt, rise_snap, oe_cnt, oe_snap;

   function automatic logic [2:0] owner_of(int s);
      case (s)
         1, 3:    return 3'd1;
         4:       return 3'd4;
         default: return 3'd6;
      endcase
   endfunction

   task automatic chk(string req, bit ok, longint act, longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         mon_we0 = 1'b0;
         mon_rd  = '0;
         // bus clock shape, master and followers (R1, R2)
         if (bus_bclk) hi_len++;
         if (!bus_bclk && prev_bclk) begin
            if (hi_len != HALF) bclk_bad = 1'b1;
            hi_len = 0;
         end
         if (bo[1] || bo[2] || fo[1] || fo[2]) slave_bad = 1'b1;
         if (bus_fs) fs_len++;
         if (bus_fs && !prev_fs) begin
            rise_snap = rise_cnt;
            rise_cnt  = 1;
            oe_snap   = oe_cnt;
            oe_cnt    = 0;
            irq_k     = 0;
         end else if (bus_bclk && !prev_bclk) begin
            rise_cnt++;
         end
         if (!bus_fs && prev_fs) begin
            fs_len_snap = fs_len;
            fs_len = 0;
         end
         if (d_oe[0]) oe_cnt++;
         // drain interrupt timing on the master node (R5, R4)
         if (eirq[0]) begin
            chk("R5 drain pulse coincides with start of owned slot",
                a_oe[0] && !prev_oe0, {a_oe[0], prev_oe0}, 2'b10);
            chk("R4 address marker at slot start", a_o[0] == 1'b1, a_o[0], 1);
            if (irq_k == 0) begin
               second = ($urandom % 2) == 1;
               if (second) begin
                  mon_wd0 = 16'($urandom);
                  mon_we0 = 1'b1;
                  slot_word[3] = mon_wd0;
               end else begin
                  slot_word[3] = 16'h0000;
               end
            end
            irq_k++;
         end
         // capture sequence per node (R7, R8)
         for (int n = 0; n < 3; n++) begin
            if (rirq[n]) begin
               chk("R8 input buffer full during capture pulse", rxf[n] == 1'b1, rxf[n], 1);
               if (got_n[n] < exp_n[n]) begin
                  int s;
                  s = exp_slot[n][got_n[n]];
                  chk("R7 captured source", rxs[n] == owner_of(s), rxs[n], owner_of(s));
                  chk("R7 captured word", rxw[n] == slot_word[s], rxw[n], slot_word[s]);
               end
               got_n[n]++;
               if (!(hold2 && n == 2)) mon_rd[n] = 1'b1;
            end
         end
         prev_bclk = bus_bclk;
         prev_fs   = bus_fs;
         prev_oe0  = a_oe[0];
      end
   end

   task automatic wait_fsync();
      @(posedge bus_fs);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic end_frame(int f);
      for (int n = 0; n < 3; n++)
         chk("R9 count of accepted words (filtered and idle slots ignored)",
             got_n[n] == exp_n[n], got_n[n], exp_n[n]);
      chk("R6 master underrun flag", und[0] == !second, und[0], !second);
      chk("R6 follower underrun flag", und[1] == skip[1], und[1], skip[1]);
      chk("R6 follower underrun flag", und[2] == skip[2], und[2], skip[2]);
      chk("R5 output buffers drained", txf == 3'b000, txf, 0);
      chk("R3 drive time per frame", oe_snap == 2 * 16 * 2 * HALF, oe_snap, 2 * 16 * 2 * HALF);
      chk("R2 bus clock periods per frame", rise_snap == 129, rise_snap, 129);
      chk("R2 frame marker width", fs_len_snap == 2 * HALF, fs_len_snap, 2 * HALF);
      chk("R1 bus clock high time", !bclk_bad, bclk_bad, 0);
      chk("R1 followers generate nothing", !slave_bad, slave_bad, 0);
      if (hold2) begin
         chk("R8 unread word overwritten by newest", rxw[2] == slot_word[4], rxw[2], slot_word[4]);
         chk("R8 newest source kept", rxs[2] == 3'd4, rxs[2], 4);
         chk("R8 buffer still full", rxf[2] == 1'b1, rxf[2], 1);
         man_rd[2] = 1'b1;
         @(negedge clk);
         man_rd[2] = 1'b0;
         chk("R8 read releases buffer", rxf[2] == 1'b0, rxf[2], 0);
         hold2 = 1'b0;
      end
   endtask

   task automatic setup_frame(int f);
      int srcs [4] = '{1, 1, 4, 6};
      int slots [4] = '{1, 3, 4, 6};
      for (int n = 0; n < 3; n++) begin
         skip[n] = (n != 0) && (($urandom % 4) == 0 || (f == 1 && n == 1));
         init_wd[n] = 16'($urandom);
         if (f == 0) rxm[n] = 8'hFF;
         else        rxm[n] = 8'($urandom);
         got_n[n] = 0;
         exp_n[n] = 0;
      end
      if (f == 2) init_wd[0] = 16'hFFFF;
      if (f == 3) init_wd[1] = 16'h8001;
      if (f == 5) begin
         rxm[2] = 8'h12;
         hold2 = 1'b1;
      end
      slot_word[1] = init_wd[0];
      slot_word[3] = 16'h0000;
      slot_word[4] = skip[1] ? 16'h0000 : init_wd[1];
      slot_word[6] = skip[2] ? 16'h0000 : init_wd[2];
      for (int n = 0; n < 3; n++)
         for (int k = 0; k < 4; k++)
            if (rxm[n][srcs[k]]) begin
               exp_slot[n][exp_n[n]] = slots[k];
               exp_n[n]++;
            end
      for (int n = 0; n < 3; n++) init_we[n] = !skip[n];
      @(negedge clk);
      init_we = '0;
   endtask

   initial begin
      void'($urandom(32'h5EED_7D31));
      init_we = '0; man_rd = '0; mon_rd = '0; mon_we0 = 1'b0; mon_wd0 = '0;
      hold2 = 1'b0; second = 1'b0; irq_k = 0;
      for (int n = 0; n < 3; n++) begin
         rxm[n] = '0; init_wd[n] = '0; got_n[n] = 0; exp_n[n] = 0; skip[n] = 1'b0;
      end
      prev_bclk = 0; prev_fs = 0; prev_oe0 = 0; bclk_bad = 0; slave_bad = 0;
      hi_len = 0; fs_len = 0; fs_len_snap = 0; rise_cnt = 0; rise_snap = 0;
      oe_cnt = 0; oe_snap = 0;
      repeat (5) @(negedge clk);
      // R10 reset state
      chk("R10 reset buffers", txf == 0 && rxf == 0, {txf, rxf}, 0);
      chk("R10 reset flags", und == 0 && eirq == 0 && rirq == 0, {und, eirq, rirq}, 0);
      chk("R10 reset bus released", a_oe == 0 && d_oe == 0, {a_oe, d_oe}, 0);
      chk("R10 reset clock idle", bo == 0 && fo == 0, {bo, fo}, 0);
      rst_n = 1'b1;
      wait_fsync();
      for (int f = 0; f < NF; f++) begin
         setup_frame(f);
         wait_fsync();
         end_frame(f);
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule